// File: doc/BRIEF.md
# GPIO Pin Drive Resolver

This block works out, for every pin of a general-purpose I/O bank, the level the pin actually settles at. Its inputs are the controller's drive settings (output data, polarity, output enable, open-drain select), the pull resistor settings, the input enable mask and a model of an external driver. The external driver model gives, per pin, whether something outside drives the pin and to what level.

From these it produces four words:
- the resolved pin levels;
- a mask of pins whose level is undefined;
- a mask of pins where the two drivers fight;
- the input word software would read.

The input word is the resolved level, gated by the input enable and then passed through the polarity inversion. A disabled input therefore reads back as its polarity bit.

The resolution is purely combinational. All four results are captured in output registers on every clock, so any change on the inputs appears one cycle later. There is no handshake: the outputs are continuous state, not a stream of items, so there is no back-pressure.

Top module: `gpio_pin_resolver`

## Requirements
- R1: The controller's drive level for a pin is its output data bit XOR its polarity bit. The controller drives the pin when the output enable bit is 1, unless R2 applies. A pin driven only by the controller takes the drive level.
- R2: When the open-drain bit of a pin is 1 and the drive level is 1, the controller does not drive that pin. The pin then resolves as if the output enable were 0. Open drain with drive level 0 drives 0.
- R3: When the controller and the external driver both drive a pin, to opposite levels, that pin's conflict bit is 1 and its level is 1 (the OR of both drivers). In every other case the conflict bit is 0.
- R4: A pin driven externally and not by the controller takes the external level, whatever its pull settings.
- R5: A pin driven by neither side resolves by its pulls:
  - pull-up set gives 1;
  - pull-down alone gives 0;
  - both set gives 1, because pull-up wins.
- R6: A pin driven by neither side and with neither pull set has its undefined bit at 1 and its level at 0. All other pins have undefined bit 0.
- R7: Input word bit = (pin level AND input enable) XOR polarity.
- R8: All four outputs are registered. They reflect the inputs present at the previous rising clock edge. While reset (active low) is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dout_i | input | NPINS | Output data bits |
| pol_i | input | NPINS | Polarity inversion bits (drive and input path) |
| oe_i | input | NPINS | Output enable bits |
| odrain_i | input | NPINS | Open-drain select bits |
| pu_i | input | NPINS | Pull-up enable bits |
| pd_i | input | NPINS | Pull-down enable bits |
| inen_i | input | NPINS | Input enable mask |
| ext_drv_i | input | NPINS | External driver active per pin |
| ext_lvl_i | input | NPINS | External driver level per pin |
| pin_o | output | NPINS | Resolved pin levels |
| undef_o | output | NPINS | Undefined-level mask |
| conflict_o | output | NPINS | Multiple-driver conflict mask |
| din_o | output | NPINS | Input word after enable and polarity |

## Verification
The resolver is tried with directed words, each of which isolates one resolution path:
- push-pull drive with and without inversion;
- open drain with drive level 1 and drive level 0;
- external drive agreeing with and opposing the controller;
- floating pins under each pull combination;
- the input mask with polarity set.

Each word uses different bits for different cases, so a single compare tells apart, for example, a lost pull-up priority from a lost open-drain suppression. Long runs of random words then mix all paths across the bank at once. Back-to-back changes separate the one-cycle register latency from a combinational or two-cycle path.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
  typedef struct packed {
    logic dout;
    logic pol;
    logic oe;
    logic odrain;
    logic pu;
    logic pd;
    logic inen;
    logic xdrv;
    logic xlvl;
  } pin_cfg_t;

  typedef struct packed {
    logic lvl;
    logic undef;
    logic conflict;
    logic din;
  } pin_res_t;
endpackage

// File: rtl/gpio_drive_stage.sv
module gpio_drive_stage #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] dout_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] oe_i,
  input  logic [NPINS-1:0] odrain_i,
  output logic [NPINS-1:0] drv_lvl_o,
  output logic [NPINS-1:0] drv_en_o
);
  always_comb begin
    drv_lvl_o = dout_i ^ pol_i;
    // open drain suppresses only a high drive
    drv_en_o  = oe_i & ~(odrain_i & drv_lvl_o);
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic drv_en_i,
  input  logic drv_lvl_i,
  input  logic xdrv_i,
  input  logic xlvl_i,
  input  logic pu_i,
  input  logic pd_i,
  output logic lvl_o,
  output logic undef_o,
  output logic conflict_o
);
  logic any_drv;

  always_comb begin
    any_drv    = drv_en_i | xdrv_i;
    conflict_o = drv_en_i & xdrv_i & (drv_lvl_i ^ xlvl_i);
    if (any_drv) begin
      lvl_o   = (xdrv_i & xlvl_i) | (drv_en_i & drv_lvl_i);
      undef_o = 1'b0;
    end else if (pu_i) begin
      lvl_o   = 1'b1;
      undef_o = 1'b0;
    end else begin
      lvl_o   = 1'b0;
      undef_o = ~pd_i;
    end
  end
endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] inen_i,
  input  logic [NPINS-1:0] pol_i,
  output logic [NPINS-1:0] din_o
);
  always_comb din_o = (lvl_i & inen_i) ^ pol_i;
endmodule

// File: rtl/gpio_pin_resolver.sv
module gpio_pin_resolver #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] dout_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] oe_i,
  input  logic [NPINS-1:0] odrain_i,
  input  logic [NPINS-1:0] pu_i,
  input  logic [NPINS-1:0] pd_i,
  input  logic [NPINS-1:0] inen_i,
  input  logic [NPINS-1:0] ext_drv_i,
  input  logic [NPINS-1:0] ext_lvl_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] undef_o,
  output logic [NPINS-1:0] conflict_o,
  output logic [NPINS-1:0] din_o
);
  import gpio_res_pkg::*;

  localparam int LastPin = NPINS - 1;

  logic [NPINS-1:0] drv_lvl, drv_en;
  logic [NPINS-1:0] lvl_c, undef_c, conf_c, din_c;
  pin_res_t [LastPin:0] res_q;

  gpio_drive_stage #(.NPINS(NPINS)) u_drive (
    .dout_i(dout_i), .pol_i(pol_i), .oe_i(oe_i), .odrain_i(odrain_i),
    .drv_lvl_o(drv_lvl), .drv_en_o(drv_en)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpio_pin_cell u_cell (
      .drv_en_i(drv_en[g]), .drv_lvl_i(drv_lvl[g]),
      .xdrv_i(ext_drv_i[g]), .xlvl_i(ext_lvl_i[g]),
      .pu_i(pu_i[g]), .pd_i(pd_i[g]),
      .lvl_o(lvl_c[g]), .undef_o(undef_c[g]), .conflict_o(conf_c[g])
    );
  end

  gpio_in_path #(.NPINS(NPINS)) u_in (
    .lvl_i(lvl_c), .inen_i(inen_i), .pol_i(pol_i), .din_o(din_c)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q[g] <= '0;
      else        res_q[g] <= '{lvl: lvl_c[g], undef: undef_c[g],
                                conflict: conf_c[g], din: din_c[g]};
    end
    assign pin_o[g]      = res_q[g].lvl;
    assign undef_o[g]    = res_q[g].undef;
    assign conflict_o[g] = res_q[g].conflict;
    assign din_o[g]      = res_q[g].din;
  end
endmodule

// File: rtl/gpio_pin_resolver_chk.sv
module gpio_pin_resolver_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] dout_i,
  input logic [NPINS-1:0] pol_i,
  input logic [NPINS-1:0] oe_i,
  input logic [NPINS-1:0] odrain_i,
  input logic [NPINS-1:0] pu_i,
  input logic [NPINS-1:0] pd_i,
  input logic [NPINS-1:0] inen_i,
  input logic [NPINS-1:0] ext_drv_i,
  input logic [NPINS-1:0] ext_lvl_i,
  input logic [NPINS-1:0] pin_o,
  input logic [NPINS-1:0] undef_o,
  input logic [NPINS-1:0] conflict_o,
  input logic [NPINS-1:0] din_o
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  AST_CONFLICT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_o & ~pin_o) == '0); // R3

  AST_CONFLICT_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (conflict_o & ~($past(oe_i) & $past(ext_drv_i))) == '0); // R3

  AST_UNDEF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_o & pin_o) == '0); // R6

  AST_UNDEF_FLOATING: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (undef_o & ($past(ext_drv_i) | $past(pu_i) | $past(pd_i))) == '0); // R6

  AST_OPEN_DRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (pin_o & $past(odrain_i & ~ext_drv_i & ~pu_i & (dout_i ^ pol_i))) == '0); // R2

  AST_DIN_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> din_o == ((pin_o & $past(inen_i)) ^ $past(pol_i))); // R7

  AST_PULLUP_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (~pin_o & $past(pu_i & ~ext_drv_i & ~oe_i)) == '0); // R5
endmodule

bind gpio_pin_resolver gpio_pin_resolver_chk #(.NPINS(NPINS)) u_chk (.*);

// File: tb/gpio_pin_resolver_tb.sv
module gpio_pin_resolver_tb;
  localparam int  N = 32;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [N-1:0] pin, und, con, din;
    string        tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] dout, pol, oe, od, pu, pd, ien, xd, xl;
  logic [N-1:0] pin_o, undef_o, conflict_o, din_o;
  int checks = 0, fails = 0;
  exp_t q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pin_resolver #(.NPINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .dout_i(dout), .pol_i(pol), .oe_i(oe),
    .odrain_i(od), .pu_i(pu), .pd_i(pd), .inen_i(ien), .ext_drv_i(xd),
    .ext_lvl_i(xl), .pin_o(pin_o), .undef_o(undef_o),
    .conflict_o(conflict_o), .din_o(din_o)
  );

  function automatic exp_t model(string tag);
    exp_t e;
    e.tag = tag;
    for (int i = 0; i < N; i++) begin
      logic lv, en;
      lv = dout[i] ^ pol[i];                       // R1
      en = oe[i] && !(od[i] && lv);                // R2
      e.con[i] = en && xd[i] && (lv != xl[i]);     // R3
      e.und[i] = 1'b0;
      if (en && xd[i])      e.pin[i] = lv | xl[i];
      else if (en)          e.pin[i] = lv;
      else if (xd[i])       e.pin[i] = xl[i];      // R4
      else if (pu[i])       e.pin[i] = 1'b1;       // R5
      else begin
        e.pin[i] = 1'b0;
        e.und[i] = !pd[i];                         // R6
      end
      e.din[i] = ien[i] ? (e.pin[i] ^ pol[i]) : pol[i]; // R7
    end
    return e;
  endfunction

  task automatic check(string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(logic [N-1:0] a_dout, a_pol, a_oe, a_od, a_pu, a_pd,
                       a_ien, a_xd, a_xl, string tag);
    @(negedge clk);
    dout = a_dout; pol = a_pol; oe = a_oe; od = a_od; pu = a_pu; pd = a_pd;
    ien = a_ien; xd = a_xd; xl = a_xl;
    q.push_back(model(tag));
  endtask

  // monitor: item pushed before an edge is due just after that edge (R8)
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " R1 pin"}, pin_o, e.pin);
      check({e.tag, " R6 undef"}, undef_o, e.und);
      check({e.tag, " R3 conflict"}, conflict_o, e.con);
      check({e.tag, " R7 din"}, din_o, e.din);
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R8 actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    dout = '1; pol = '1; oe = '1; od = '0; pu = '1; pd = '0;
    ien = '1; xd = '1; xl = '1;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check("R8 reset pin", pin_o, '0);
    check("R8 reset undef", undef_o, '0);
    check("R8 reset conflict", conflict_o, '0);
    check("R8 reset din", din_o, '0);
    @(negedge clk); rst_n = 1;
    // R1 push-pull, with and without inversion
    drive(32'h0000_00F0, 32'h0000_0F00, 32'h0000_0FFF, '0, '0, '1, '1, '0, '0, "R1 push-pull");
    // R2 open drain: high suppressed (floats to pull), low driven
    drive(32'h0000_000F, 32'h0000_0000, 32'h0000_00FF, 32'h0000_00FF,
          32'h0000_0003, 32'h0000_FFFC, '1, '0, '0, "R2 open-drain");
    // R3 conflicts and agreements
    drive(32'h0000_00FF, '0, 32'h0000_FFFF, '0, '0, '0, '1,
          32'h0000_FFFF, 32'h0000_0F0F, "R3 conflict");
    // R4 external only, pulls ignored
    drive('0, '0, '0, '0, 32'h00FF_00FF, 32'hFF00_FF00, '1,
          '1, 32'h0F0F_0F0F, "R4 external");
    // R5 and R6 floating pins under each pull combination
    drive('0, '0, '0, '0, 32'h0000_0005, 32'h0000_0006, '1, '0, '0, "R5 pulls");
    // R7 input mask and polarity
    drive('1, 32'h00FF_0000, '1, '0, '0, '0, 32'h0F0F_0F0F, '0, '0, "R7 din mask");
    // R8 back-to-back changes, every cycle different
    for (int k = 0; k < 400; k++)
      drive($urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, "R8 random");
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule